// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Edge and Level Interrupts

This block is a register-mapped general-purpose I/O unit for up to sixteen pins (twelve by default). Every pin can be an output driven from a data register or an input sampled through a two-flop synchroniser. Each pin also has its own event detector. The detector can fire on a rising edge, a falling edge, either edge, a high level or a low level.

Detected events latch into a per-pin status bit, which is cleared by a write-one strobe. A status bit that is enabled and not masked drives a single registered interrupt line. Masks are changed through a pair of write-one registers, one that sets mask bits and one that clears them. A software reset register holds all configuration at its default value while bit 0 is set.

The bus is word addressed with a 4-bit offset. A write takes effect on the clock edge where `bus_we` is high. The read data is registered and appears one cycle after the address is presented.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every offset reads 0, `pin_oe` and `pin_out` are 0, and `irq_out` is low.
- R2: Offset 8 holds the direction register and offset 6 holds the output data. `pin_oe[i]` equals direction bit i and `pin_out` follows the output data. Written bits at or above the pin count are dropped and read back as 0.
- R3: Offset 7 returns the pin input levels after the two-flop synchroniser.
- R4: Writing 1 to bit i at offset 4 masks pin i. Writing 1 to bit i at offset 5 unmasks it. Zero bits leave the mask unchanged, and offset 4 reads back the current mask.
- R5: `irq_out` is a registered OR of (status AND enable AND NOT mask). Masking a pin drops the interrupt but keeps its status bit set.
- R6: Offset 1 returns the latched status bits, and offset 2 returns status AND enable AND NOT mask. Bits at or above the pin count read 0.
- R7: Writing 1 to bit i at offset 3 clears status bit i. Zero bits have no effect.
- R8: The mode of pin i (i<8) is in offset 9 bits [4i+2:4i]. The mode of pin i (i>=8) is in offset 10 bits [4(i-8)+2:4(i-8)]. Bit 3 of each lane reads 0. Codes: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 both edges, 5 to 7 never fire.
- R9: In a level mode the status bit is set again on every cycle the level is present, so a clear does not stick while that level holds.
- R10: No event sets a status bit while that pin's enable bit (offset 0) is 0.
- R11: While bit 0 of offset 15 is 1, the enable, mask, output, direction, mode and status registers are held at 0 and writes to them are ignored. Bit 0 of offset 15 reads back.
- R12: Offsets 11 to 14 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the address |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The bench runs each detector mode through one transition that should fire and one that should not. A swapped mode code or an inverted edge compare therefore leaves a status bit wrong. For a pin above 7 it checks that the mode lane in the second register is decoded. A design that ignores that register never raises the interrupt.

It checks that the status bit stays set while the mask removes the interrupt, and that a level mode sets the bit again right after a clear. A design that clears status on mask, or treats level codes as edges, fails those checks. It also confirms that software-reset hold, reserved offsets and out-of-range direction bits read 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int MODE_W = 3;
  localparam int LANE_W = 4;
  localparam int LANES_PER_REG = DATA_W / LANE_W;

  localparam logic [ADDR_W-1:0] OFS_EN    = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_ST    = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_MSET  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_MCLR  = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_IN    = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_MODE0 = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_MODE1 = 4'd10;
  localparam logic [ADDR_W-1:0] OFS_SRST  = 4'd15;

  localparam logic [MODE_W-1:0] MD_FALL = 3'd0;
  localparam logic [MODE_W-1:0] MD_RISE = 3'd1;
  localparam logic [MODE_W-1:0] MD_LOW  = 3'd2;
  localparam logic [MODE_W-1:0] MD_HIGH = 3'd3;
  localparam logic [MODE_W-1:0] MD_BOTH = 3'd4;

  function automatic logic [ADDR_W-1:0] mode_ofs(input int pin);
    return (pin < LANES_PER_REG) ? OFS_MODE0 : OFS_MODE1;
  endfunction

  function automatic int mode_lane(input int pin);
    return (pin % LANES_PER_REG) * LANE_W;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_det.sv
module gpio_det
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rst,
  input  logic              lvl,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              clr,
  output logic              st
);
  logic prev;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  always_comb begin
    case (mode)
      MD_FALL: hit = prev & ~lvl;
      MD_RISE: hit = ~prev & lvl;
      MD_LOW:  hit = ~lvl;
      MD_HIGH: hit = lvl;
      MD_BOTH: hit = prev ^ lvl;
      default: hit = 1'b0;
    endcase
  end

  // a new event wins over a clear strobe in the same cycle
  always_ff @(posedge clk) begin
    if (rst || cfg_rst)  st <= 1'b0;
    else if (en && hit)  st <= 1'b1;
    else if (clr)        st <= 1'b0;
  end

  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(st) |-> $past(en)); // R10
  AST_LEVEL_RESET: assert property (@(posedge clk) disable iff (rst)
    (en && !cfg_rst && mode == MD_HIGH && lvl) |=> st); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !en) |=> !st); // R7
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0]  en_q, mask_q, out_q, dir_q;
  logic [MODE_W-1:0] mode_q [NPINS];
  logic              soft_q;
  logic [NPINS-1:0]  lvl, st, clr_vec, pend;
  logic [NPINS-1:0]  wr_bits;
  logic [DATA_W-1:0] mode0_word, mode1_word, rd_mux;
  logic              irq_q;
  logic              cfg_hold;
  logic              unused_wdata;

  assign wr_bits      = bus_wdata[NPINS-1:0];
  assign cfg_hold     = rst || soft_q;
  assign unused_wdata = &{1'b0, bus_wdata};

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)                              soft_q <= 1'b0;
    else if (bus_we && bus_addr == OFS_SRST) soft_q <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (cfg_hold) begin
      en_q   <= '0;
      mask_q <= '0;
      out_q  <= '0;
      dir_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_EN:   en_q   <= wr_bits;
        OFS_MSET: mask_q <= mask_q | wr_bits;
        OFS_MCLR: mask_q <= mask_q & ~wr_bits;
        OFS_OUT:  out_q  <= wr_bits;
        OFS_DIR:  dir_q  <= wr_bits;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_hold) begin
      for (int i = 0; i < NPINS; i++) mode_q[i] <= '0;
    end else if (bus_we) begin
      for (int i = 0; i < NPINS; i++)
        if (bus_addr == mode_ofs(i)) mode_q[i] <= bus_wdata[mode_lane(i) +: MODE_W];
    end
  end

  assign clr_vec = (bus_we && bus_addr == OFS_CLR) ? wr_bits : '0;

  for (genvar g = 0; g < NPINS; g++) begin : g_det
    gpio_det u_det (
      .clk(clk), .rst(rst), .cfg_rst(soft_q), .lvl(lvl[g]),
      .en(en_q[g]), .mode(mode_q[g]), .clr(clr_vec[g]), .st(st[g])
    );
  end

  assign pend = st & en_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end

  always_comb begin
    mode0_word = '0;
    mode1_word = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (mode_ofs(i) == OFS_MODE0) mode0_word[mode_lane(i) +: MODE_W] = mode_q[i];
      else                          mode1_word[mode_lane(i) +: MODE_W] = mode_q[i];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_EN:    rd_mux = DATA_W'(en_q);
      OFS_ST:    rd_mux = DATA_W'(st);
      OFS_PEND:  rd_mux = DATA_W'(pend);
      OFS_MSET:  rd_mux = DATA_W'(mask_q);
      OFS_OUT:   rd_mux = DATA_W'(out_q);
      OFS_IN:    rd_mux = DATA_W'(lvl);
      OFS_DIR:   rd_mux = DATA_W'(dir_q);
      OFS_MODE0: rd_mux = mode0_word;
      OFS_MODE1: rd_mux = mode1_word;
      OFS_SRST:  rd_mux = DATA_W'(soft_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_out = irq_q;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MSET && !soft_q) |=>
      ((mask_q & $past(wr_bits)) == $past(wr_bits))); // R4
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MSET && !soft_q && wr_bits == '1) |=> ##1 !irq_out); // R5
  AST_ST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_ST) |=> (bus_rdata >> NPINS) == '0); // R6
  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> (dir_q == '0 && en_q == '0 && mask_q == '0 && st == '0)); // R11
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;
  localparam int SETTLE = 8;
  localparam int NVEC = 11;
  // {mode[2:0], level before, level after, expected status}
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b1, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] allz;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);

    // R1: every offset reads 0 after reset
    allz = '0;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      allz = allz | v;
    end
    chk("R1 all offsets zero", allz, 32'h0);
    chk("R1 pin_oe/pin_out/irq", {pin_oe, pin_out, 7'd0, irq_out}, 32'h0);

    // R8 R9 R10: mode table on pin 3, lane bits [14:12] of offset 9
    wr(4'd0, 32'h008);
    for (int k = 0; k < NVEC; k++) begin
      wr(4'd9, {17'd0, VEC[k][5:3], 12'd0});
      @(negedge clk); pin_in[3] = VEC[k][2];
      wait_cyc(SETTLE);
      wr(4'd3, 32'h008);
      @(negedge clk); pin_in[3] = VEC[k][1];
      wait_cyc(SETTLE);
      rd(4'd1, v);
      chk($sformatf("R8 mode table entry %0d", k), v & 32'h008, {28'd0, VEC[k][0], 3'd0});
    end

    // R8 mode register packing
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10, v);
    chk("R8 mode1 lanes", v, 32'h0000_7777);
    wr(4'd9, 32'h7654_3210);
    rd(4'd9, v);
    chk("R8 mode0 lanes", v, 32'h7654_3210);

    // R2 direction and output
    wr(4'd6, 32'h0000_0A5A);
    wr(4'd8, 32'hFFFF_F0FF);
    @(negedge clk);
    chk("R2 pin_out", 32'(pin_out), 32'h0A5A);
    chk("R2 pin_oe", 32'(pin_oe), 32'h00FF);
    rd(4'd8, v);
    chk("R2 direction upper bits dropped", v, 32'h0000_00FF);
    wr(4'd8, 32'h0);

    // R3 input levels
    @(negedge clk); pin_in = 12'h5C3;
    wait_cyc(4);
    rd(4'd7, v);
    chk("R3 input data", v, 32'h5C3);

    // R4 mask set/clear
    wr(4'd4, 32'h00F);
    rd(4'd4, v);
    chk("R4 mask set", v, 32'h00F);
    wr(4'd4, 32'h0F0);
    rd(4'd4, v);
    chk("R4 mask set keeps zero bits", v, 32'h0FF);
    wr(4'd5, 32'h003);
    rd(4'd4, v);
    chk("R4 mask clear", v, 32'h0FC);
    wr(4'd5, 32'hFFF);

    // R5 R6 R7 interrupt path on pin 9, rising edge in offset 10 bits [6:4]
    wr(4'd9, 32'h0);
    wr(4'd10, 32'h0000_0010);
    @(negedge clk); pin_in = '0;
    wait_cyc(SETTLE);
    wr(4'd0, 32'h200);
    wr(4'd3, 32'hFFF);
    @(negedge clk); pin_in[9] = 1'b1;
    wait_cyc(SETTLE);
    chk("R5 irq raised", {31'd0, irq_out}, 32'h1);
    rd(4'd1, v);
    chk("R6 status latched", v, 32'h200);
    rd(4'd2, v);
    chk("R6 unmasked pending", v, 32'h200);
    wr(4'd4, 32'h200);
    wait_cyc(3);
    chk("R5 irq masked", {31'd0, irq_out}, 32'h0);
    rd(4'd1, v);
    chk("R5 status kept under mask", v, 32'h200);
    rd(4'd2, v);
    chk("R6 pending hides masked", v, 32'h0);
    wr(4'd5, 32'h200);
    wait_cyc(3);
    chk("R5 irq after unmask", {31'd0, irq_out}, 32'h1);
    wr(4'd3, 32'h100);
    rd(4'd1, v);
    chk("R7 zero bits keep status", v, 32'h200);
    wr(4'd3, 32'h200);
    wait_cyc(3);
    rd(4'd1, v);
    chk("R7 status cleared", v, 32'h0);
    chk("R7 irq dropped", {31'd0, irq_out}, 32'h0);

    // R10 event ignored while enable is 0
    @(negedge clk); pin_in[9] = 1'b0;
    wait_cyc(SETTLE);
    wr(4'd0, 32'h0);
    @(negedge clk); pin_in[9] = 1'b1;
    wait_cyc(SETTLE);
    rd(4'd1, v);
    chk("R10 disabled pin no status", v, 32'h0);

    // R9 level high on pin 0 re-sets after clear
    wr(4'd10, 32'h0);
    wr(4'd9, 32'h3);
    wr(4'd0, 32'h001);
    @(negedge clk); pin_in[0] = 1'b1;
    wait_cyc(SETTLE);
    wr(4'd3, 32'h001);
    rd(4'd1, v);
    chk("R9 level status returns", v & 32'h1, 32'h1);
    @(negedge clk); pin_in[0] = 1'b0;
    wait_cyc(SETTLE);
    wr(4'd3, 32'h001);
    rd(4'd1, v);
    chk("R9 clear sticks once level gone", v & 32'h1, 32'h0);

    // R11 soft reset
    wr(4'd4, 32'h0F0);
    wr(4'd15, 32'h1);
    rd(4'd15, v);
    chk("R11 reset bit reads back", v, 32'h1);
    wr(4'd8, 32'hFFF);
    rd(4'd8, v);
    chk("R11 writes ignored while held", v, 32'h0);
    wr(4'd15, 32'h0);
    allz = '0;
    for (int a = 0; a < 11; a++) begin
      if (a == 7) continue;
      rd(4'(a), v);
      allz = allz | v;
    end
    chk("R11 config back to defaults", allz, 32'h0);

    // R12 reserved offsets
    wr(4'd12, 32'hFFFF_FFFF);
    wr(4'd14, 32'hFFFF_FFFF);
    rd(4'd12, v);
    chk("R12 reserved 12 reads 0", v, 32'h0);
    rd(4'd14, v);
    chk("R12 reserved 14 reads 0", v, 32'h0);
    rd(4'd8, v);
    chk("R12 reserved write left direction", v, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule